// File: doc/BRIEF.md
# Unified Register Renamer

This block renames the register operands of a decode group of up to four instructions in the same cycle that the group is decoded. Integer and floating-point architectural names are kept apart in one mapping table, but both classes draw their destinations from a single shared pool of physical tags. Renaming gives every new result its own tag, which removes write-after-read and write-after-write hazards between instructions in flight.

Out of reset every architectural register of both classes points at physical tag 0, which stands for the all-zero value. The remaining tags wait in a FIFO free list in ascending order. For each slot the block reports the physical tags of its two sources, the freshly allocated destination tag and the tag that destination named before. That last tag is handed back through the release port when the instruction commits. A source that names a destination written by an earlier slot of the same group picks up that slot's new tag. A group that needs more tags than the free list holds is stalled as a whole.

Top module: `rename_unit`

## Requirements
- R1: Out of reset every architectural register reads as tag 0, and the free list hands out tags 1, 2, 3 and so on in ascending order, one for each destination. Tag 0 is never allocated.
- R2: A source reads the tag last committed for its register. The previous-tag output of a slot gives the mapping its destination held before the group.
- R3: Integer register 0 (class bit 0, index 0) always reads as tag 0. As a destination it takes no tag, and both its destination and previous-tag outputs are 0.
- R4: An integer and a floating-point register with the same index (class bit 1 means floating point) are mapped independently.
- R5: A source that names the destination of an earlier slot in the same group gets that slot's new tag. When several earlier slots write it, the nearest one wins.
- R6: When an earlier slot of the group writes the same destination, the previous-tag output of a later slot is the earlier slot's new tag.
- R7: When the group needs more tags than are free, `ren_stall` is 1. No tag is consumed and no mapping changes.
- R8: Released tags go to the back of the free list in slot order. They can be allocated from the next cycle onward, not in the cycle they are released.
- R9: A release of tag 0 is ignored.
- R10: A slot that is not valid, or has no destination, consumes no tag. Tags in a group are taken by the slots that need them, starting with the lowest slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | SLOTS | Slot holds an instruction |
| ren_dst_en | input | SLOTS | Slot writes a destination |
| ren_dst_fp | input | SLOTS | Destination class, 1 = floating point |
| ren_dst_idx | input | SLOTS*AW | Destination architectural index |
| ren_src1_fp | input | SLOTS | First source class |
| ren_src1_idx | input | SLOTS*AW | First source index |
| ren_src2_fp | input | SLOTS | Second source class |
| ren_src2_idx | input | SLOTS*AW | Second source index |
| rel_valid | input | SLOTS | Commit release request per lane |
| rel_tag | input | SLOTS*TW | Tag to return to the free list |
| ren_stall | output | 1 | Group held for lack of free tags |
| ren_src1_tag | output | SLOTS*TW | Physical tag of first source |
| ren_src2_tag | output | SLOTS*TW | Physical tag of second source |
| ren_dst_tag | output | SLOTS*TW | Newly allocated destination tag |
| ren_old_tag | output | SLOTS*TW | Prior mapping of the destination |

## Verification
Allocation and commit release can happen in the same cycle. The bench provokes this by draining the free list to empty and then releasing tags in the same cycle that a one-destination group is offered. The group must still stall, because released tags only count from the next cycle. The following cycles check that a group of three still stalls with only two real tags returned (the tag-0 release is dropped), and that a group of two receives the released tags in slot order.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int MAX_SLOTS = 8;

  // number of set bits in v below position n
  function automatic logic [3:0] ones_below(input logic [MAX_SLOTS-1:0] v, input int n);
    logic [3:0] c;
    c = '0;
    for (int k = 0; k < MAX_SLOTS; k++)
      if (k < n && v[k]) c = c + 4'd1;
    return c;
  endfunction
endpackage

// File: rtl/rename_freelist.sv
module rename_freelist #(
  parameter int SLOTS     = 4,
  parameter int PHYS_REGS = 32,
  localparam int TW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       pop_cnt,
  input  logic [SLOTS-1:0]    push_vld,
  input  logic [SLOTS*TW-1:0] push_tag,
  output logic [SLOTS*TW-1:0] peek_tag,
  output logic [CW-1:0]       free_cnt
);
  import rename_pkg::*;
  localparam int ML = MAX_SLOTS;

  logic [TW-1:0] ring_q [PHYS_REGS];
  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] push_cnt;

  assign push_cnt = CW'(ones_below(ML'(push_vld), SLOTS));
  assign free_cnt = cnt_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_peek
    assign peek_tag[k*TW +: TW] = ring_q[head_q + TW'(k)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++) ring_q[i] <= TW'(i + 1);
      head_q <= '0;
      tail_q <= TW'(PHYS_REGS - 1);
      cnt_q  <= CW'(PHYS_REGS - 1);
    end else begin
      for (int k = 0; k < SLOTS; k++)
        if (push_vld[k])
          ring_q[tail_q + TW'(ones_below(ML'(push_vld), k))] <= push_tag[k*TW +: TW];
      head_q <= head_q + TW'(pop_cnt);
      tail_q <= tail_q + TW'(push_cnt);
      cnt_q  <= cnt_q + push_cnt - pop_cnt;
    end
  end
endmodule

// File: rtl/rename_maptable.sv
module rename_maptable #(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 32,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int KW = AW + 1,
  localparam int TW = $clog2(PHYS_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS*KW-1:0] src1_key,
  input  logic [SLOTS*KW-1:0] src2_key,
  input  logic [SLOTS*KW-1:0] dst_key,
  input  logic [SLOTS-1:0]    wr_en,
  input  logic [SLOTS*TW-1:0] wr_tag,
  output logic [SLOTS*TW-1:0] src1_tag,
  output logic [SLOTS*TW-1:0] src2_tag,
  output logic [SLOTS*TW-1:0] old_tag
);
  logic [TW-1:0] map_q [2*ARCH_REGS];

  // committed mapping, overridden by the nearest earlier writer in the group
  function automatic logic [TW-1:0] lookup(input logic [KW-1:0] key, input int upto);
    logic [TW-1:0] t;
    t = map_q[key];
    for (int j = 0; j < SLOTS; j++)
      if (j < upto && wr_en[j] && dst_key[j*KW +: KW] == key) t = wr_tag[j*TW +: TW];
    if (key == '0) t = '0;
    return t;
  endfunction

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      src1_tag[i*TW +: TW] = lookup(src1_key[i*KW +: KW], i);
      src2_tag[i*TW +: TW] = lookup(src2_key[i*KW +: KW], i);
      old_tag[i*TW +: TW]  = lookup(dst_key[i*KW +: KW], i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 2*ARCH_REGS; r++) map_q[r] <= '0;
    end else begin
      for (int j = 0; j < SLOTS; j++)
        if (wr_en[j]) map_q[dst_key[j*KW +: KW]] <= wr_tag[j*TW +: TW];
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 32,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int KW = AW + 1,
  localparam int TW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SLOTS-1:0]    ren_valid,
  input  logic [SLOTS-1:0]    ren_dst_en,
  input  logic [SLOTS-1:0]    ren_dst_fp,
  input  logic [SLOTS*AW-1:0] ren_dst_idx,
  input  logic [SLOTS-1:0]    ren_src1_fp,
  input  logic [SLOTS*AW-1:0] ren_src1_idx,
  input  logic [SLOTS-1:0]    ren_src2_fp,
  input  logic [SLOTS*AW-1:0] ren_src2_idx,
  input  logic [SLOTS-1:0]    rel_valid,
  input  logic [SLOTS*TW-1:0] rel_tag,
  output logic                ren_stall,
  output logic [SLOTS*TW-1:0] ren_src1_tag,
  output logic [SLOTS*TW-1:0] ren_src2_tag,
  output logic [SLOTS*TW-1:0] ren_dst_tag,
  output logic [SLOTS*TW-1:0] ren_old_tag
);
  import rename_pkg::*;
  localparam int ML = MAX_SLOTS;

  logic [SLOTS*KW-1:0] s1_key, s2_key, d_key;
  logic [SLOTS-1:0]    dst_need, alloc_fire, push_vld;
  logic [SLOTS*TW-1:0] peek_tag, new_tag, map_old;
  logic [CW-1:0]       need_cnt, pop_cnt, free_cnt;
  logic                accept;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign s1_key[i*KW +: KW] = {ren_src1_fp[i], ren_src1_idx[i*AW +: AW]};
    assign s2_key[i*KW +: KW] = {ren_src2_fp[i], ren_src2_idx[i*AW +: AW]};
    assign d_key[i*KW +: KW]  = {ren_dst_fp[i], ren_dst_idx[i*AW +: AW]};
    assign dst_need[i] = ren_valid[i] && ren_dst_en[i] && (d_key[i*KW +: KW] != '0);
    assign push_vld[i] = rel_valid[i] && (rel_tag[i*TW +: TW] != '0);
    assign ren_dst_tag[i*TW +: TW] = dst_need[i] ? new_tag[i*TW +: TW] : '0;
    assign ren_old_tag[i*TW +: TW] = dst_need[i] ? map_old[i*TW +: TW] : '0;
  end

  assign need_cnt   = CW'(ones_below(ML'(dst_need), SLOTS));
  assign accept     = (need_cnt <= free_cnt);
  assign ren_stall  = !accept;
  assign alloc_fire = dst_need & {SLOTS{accept}};
  assign pop_cnt    = accept ? need_cnt : '0;

  // slot i takes the free-list entry numbered by the needy slots below it
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      int p;
      p = int'(ones_below(ML'(dst_need), i));
      new_tag[i*TW +: TW] = peek_tag[p*TW +: TW];
    end
  end

  rename_freelist #(.SLOTS(SLOTS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk(clk), .rst_n(rst_n), .pop_cnt(pop_cnt), .push_vld(push_vld),
    .push_tag(rel_tag), .peek_tag(peek_tag), .free_cnt(free_cnt)
  );

  rename_maptable #(.SLOTS(SLOTS), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk(clk), .rst_n(rst_n), .src1_key(s1_key), .src2_key(s2_key), .dst_key(d_key),
    .wr_en(alloc_fire), .wr_tag(new_tag), .src1_tag(ren_src1_tag),
    .src2_tag(ren_src2_tag), .old_tag(map_old)
  );
endmodule

// File: rtl/rename_unit_sva.sv
module rename_unit_sva #(
  parameter int SLOTS     = 4,
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 32,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int TW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SLOTS-1:0]    ren_valid,
  input logic [SLOTS-1:0]    ren_src1_fp,
  input logic [SLOTS*AW-1:0] ren_src1_idx,
  input logic [SLOTS*TW-1:0] ren_src1_tag,
  input logic [SLOTS-1:0]    dst_need,
  input logic [SLOTS*TW-1:0] ren_dst_tag,
  input logic                accept,
  input logic                ren_stall,
  input logic [CW-1:0]       free_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(PHYS_REGS - 1)); // R8

  AST_STALL_HOLDS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |=> free_cnt >= $past(free_cnt)); // R7

  for (genvar i = 0; i < SLOTS; i++) begin : g_a
    AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid[i] && !ren_src1_fp[i] && ren_src1_idx[i*AW +: AW] == '0)
        |-> ren_src1_tag[i*TW +: TW] == '0); // R3

    AST_NO_TAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dst_need[i]) |-> ren_dst_tag[i*TW +: TW] != '0); // R1

    for (genvar j = i + 1; j < SLOTS; j++) begin : g_pair
      AST_DISTINCT_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dst_need[i] && dst_need[j])
          |-> ren_dst_tag[i*TW +: TW] != ren_dst_tag[j*TW +: TW]); // R10
    end
  end
endmodule

bind rename_unit rename_unit_sva #(.SLOTS(SLOTS), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_sva (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src1_fp(ren_src1_fp),
  .ren_src1_idx(ren_src1_idx), .ren_src1_tag(ren_src1_tag), .dst_need(dst_need),
  .ren_dst_tag(ren_dst_tag), .accept(accept), .ren_stall(ren_stall), .free_cnt(free_cnt)
);

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [3:0]  v, den, dfp, s1fp, s2fp, rv;
  logic [19:0] didx, s1idx, s2idx, rtag;
  logic        stall;
  logic [19:0] o_s1, o_s2, o_d, o_old;
  int checks = 0, fails = 0;
  bit done = 0;

  rename_unit dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(v), .ren_dst_en(den), .ren_dst_fp(dfp),
    .ren_dst_idx(didx), .ren_src1_fp(s1fp), .ren_src1_idx(s1idx), .ren_src2_fp(s2fp),
    .ren_src2_idx(s2idx), .rel_valid(rv), .rel_tag(rtag), .ren_stall(stall),
    .ren_src1_tag(o_s1), .ren_src2_tag(o_s2), .ren_dst_tag(o_d), .ren_old_tag(o_old)
  );

  function automatic int tg(input logic [19:0] o, input int s);
    return int'(o[s*5 +: 5]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear();
    v = '0; den = '0; dfp = '0; s1fp = '0; s2fp = '0; rv = '0;
    didx = '0; s1idx = '0; s2idx = '0; rtag = '0;
  endtask

  task automatic put(input int s, input bit has_d, input bit fd, input int id,
                     input bit f1, input int i1, input bit f2, input int i2);
    v[s] = 1'b1; den[s] = has_d; dfp[s] = fd; didx[s*5 +: 5] = 5'(id);
    s1fp[s] = f1; s1idx[s*5 +: 5] = 5'(i1); s2fp[s] = f2; s2idx[s*5 +: 5] = 5'(i2);
  endtask

  task automatic release_tag(input int s, input int t);
    rv[s] = 1'b1; rtag[s*5 +: 5] = 5'(t);
  endtask

  task automatic tick();
    @(posedge clk); #1; clear();
  endtask

  task automatic t_reset();
    @(negedge clk);
    put(0, 1, 0, 3, 0, 5, 1, 7);
    #1;
    chk("R1 src int5", tg(o_s1, 0), 0);
    chk("R1 src fp7", tg(o_s2, 0), 0);
    chk("R1 first tag", tg(o_d, 0), 1);
    chk("R2 old tag", tg(o_old, 0), 0);
    chk("R7 no stall", int'(stall), 0);
    tick();
  endtask

  task automatic t_group();
    @(negedge clk);
    put(0, 1, 1, 3, 0, 3, 1, 3);
    put(1, 1, 0, 3, 1, 3, 0, 3);
    put(2, 1, 0, 3, 0, 3, 0, 0);
    put(3, 1, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R2 committed src", tg(o_s1, 0), 1);
    chk("R4 fp3 apart", tg(o_s2, 0), 0);
    chk("R10 slot0 tag", tg(o_d, 0), 2);
    chk("R5 bypass fp3", tg(o_s1, 1), 2);
    chk("R4 int3 kept", tg(o_s2, 1), 1);
    chk("R10 slot1 tag", tg(o_d, 1), 3);
    chk("R2 slot1 old", tg(o_old, 1), 1);
    chk("R5 nearest writer", tg(o_s1, 2), 3);
    chk("R6 old in group", tg(o_old, 2), 3);
    chk("R10 slot2 tag", tg(o_d, 2), 4);
    chk("R3 zero dst", tg(o_d, 3), 0);
    chk("R3 zero old", tg(o_old, 3), 0);
    chk("R3 zero src", tg(o_s1, 3), 0);
    tick();
  endtask

  task automatic t_idle_slots();
    @(negedge clk);
    v[0] = 1'b0; den[0] = 1'b1; didx[4:0] = 5'd9;
    put(1, 0, 0, 9, 0, 1, 0, 2);
    #1;
    chk("R10 no dst tag", tg(o_d, 1), 0);
    tick();
    @(negedge clk);
    put(2, 1, 0, 5, 0, 3, 1, 3);
    #1;
    chk("R10 unused slots", tg(o_d, 2), 5);
    chk("R2 int3 now", tg(o_s1, 2), 4);
    chk("R2 fp3 now", tg(o_s2, 2), 2);
    tick();
  endtask

  task automatic t_drain();
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      for (int s = 0; s < 4; s++) put(s, 1, 1, 8 + 4*g + s, 0, 0, 0, 0);
      #1;
      for (int s = 0; s < 4; s++) chk("R1 ascending", tg(o_d, s), 6 + 4*g + s);
      tick();
    end
    @(negedge clk);
    put(0, 1, 0, 20, 0, 0, 0, 0);
    put(1, 1, 0, 21, 0, 0, 0, 0);
    #1;
    chk("R7 exact fit", int'(stall), 0);
    chk("R1 last tag", tg(o_d, 1), 31);
    tick();
  endtask

  task automatic t_stall_release();
    @(negedge clk);
    put(0, 1, 0, 3, 0, 0, 0, 0);
    release_tag(0, 3); release_tag(1, 0); release_tag(2, 1);
    #1;
    chk("R8 frees not yet", int'(stall), 1);
    tick();
    @(negedge clk);
    put(0, 1, 0, 6, 0, 3, 0, 0);
    put(1, 1, 0, 7, 0, 0, 0, 0);
    put(2, 1, 0, 8, 0, 0, 0, 0);
    #1;
    chk("R7 map unchanged", tg(o_s1, 0), 4);
    chk("R9 zero not freed", int'(stall), 1);
    tick();
    @(negedge clk);
    put(0, 1, 1, 30, 0, 0, 0, 0);
    put(1, 1, 1, 31, 0, 0, 0, 0);
    #1;
    chk("R8 accepted", int'(stall), 0);
    chk("R8 order first", tg(o_d, 0), 3);
    chk("R8 order second", tg(o_d, 1), 1);
    tick();
    @(negedge clk);
    put(0, 1, 1, 29, 0, 0, 0, 0);
    #1;
    chk("R9 pool empty", int'(stall), 1);
    tick();
  endtask

  task automatic finish_bench();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_bench();
  end

  initial begin
    clear();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_group();
    t_idle_slots();
    t_drain();
    t_stall_release();
    finish_bench();
  end
endmodule